// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

This block walks one transmit frame descriptor that sits in a ring in local descriptor memory. It turns the descriptor's buffer entries into an ordered stream of read requests, one request for each scattered piece of the frame. A start strobe carries the descriptor's ring index. The ring base is a 256-byte-aligned address whose bits [35:8] arrive as an input. Each descriptor occupies 128 bytes, so a ring of 256 descriptors spans 32 KB, and the block computes each descriptor's location from the base and the index.

A descriptor holds a 5-bit buffer count and up to 20 buffer entries. Each entry carries a 36-bit address split into a 32-bit low part and a 4-bit high nibble, plus a 12-bit length. Before issuing anything, the engine scans every length. It rejects a descriptor whose count is out of range, whose single buffer is longer than 4092 bytes, or whose frame would exceed 8192 bytes. A rejected descriptor raises an error pulse and produces no requests. A good descriptor is emitted entry by entry. The engine ends with a done pulse that carries the total byte count.

The descriptor memory port is read-only and returns a 16-bit little-endian halfword one cycle after a read strobe. The host memory transfer itself and any byte-count bookkeeping live outside this block.

Top module: `tfd_gather`

## Requirements
- R1: After reset `busy`, `req_valid`, `mem_rd`, `done` and `err` are all low.
- R2: Every descriptor read targets byte address `{ring_base, 8'h00} + start_idx*128 + offset`. The buffer count is bits 4:0 of descriptor byte 3, and bits 7:5 of that byte are ignored. Entry k starts at byte 4+6k: a 32-bit low address (little endian) followed by a halfword whose bits 3:0 are address bits [35:32] and whose bits 15:4 are the length.
- R3: Requests appear in entry order 0..count-1 with the entry's full address and length. While `req_ready` is low, the request stays on the port unchanged.
- R4: `done` is high for exactly the one cycle after the last request is accepted. In that cycle `done_bytes` equals the sum of all entry lengths.
- R5: A count of 0 or above 20 gives a one-cycle `err` pulse and no request.
- R6: An entry length above 4092 gives `err` and no request. A length of exactly 4092 is accepted.
- R7: A frame total above 8192 bytes gives `err` and no request. A total of exactly 8192 is accepted.
- R8: `start` is ignored while `busy` is high.
- R9: A descriptor with the maximum count of 20 emits all 20 requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking one descriptor |
| start_idx | input | 8 | Descriptor index within the ring |
| ring_base | input | 28 | Ring base address bits [35:8] |
| busy | output | 1 | A descriptor is being processed |
| mem_rd | output | 1 | Descriptor memory read strobe |
| mem_addr | output | 36 | Byte address of the halfword being read |
| mem_rdata | input | 16 | Halfword returned one cycle after `mem_rd` |
| req_valid | output | 1 | Buffer request valid |
| req_ready | input | 1 | Buffer request accepted |
| req_addr | output | 36 | Buffer start address |
| req_len | output | 12 | Buffer length in bytes |
| done | output | 1 | One-cycle completion pulse |
| done_bytes | output | 14 | Frame byte total, valid with `done` |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The bench builds the engine with its default parameters: 20 entries at most, 12-bit lengths, a 4092-byte buffer limit and an 8192-byte frame limit. With these values a full 20-entry descriptor fits in a short run, and lengths can be chosen to land exactly on each limit and one byte past it. The bench uses a ring base with high address bits set, so any error in the base-plus-index arithmetic shows up on the address port. Back-pressure patterns on `req_ready` show whether each request is held until it is accepted.

// File: rtl/tfd_gather.sv
module tfd_gather #(
  parameter int ADDR_W     = 36,
  parameter int LEN_W      = 12,
  parameter int IDX_W      = 8,
  parameter int BASE_SHIFT = 8,
  parameter int DESC_LOG   = 7,
  parameter int MAX_BUFS   = 20,
  parameter int BUF_MAX    = 4092,
  parameter int FRAME_MAX  = 8192,
  localparam int BASE_W    = ADDR_W - BASE_SHIFT,
  localparam int HI_W      = ADDR_W - 32,
  localparam int CNT_W     = 5,
  localparam int SUM_W     = $clog2(MAX_BUFS * (2 ** LEN_W)) + 1,
  localparam int OUT_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [BASE_W-1:0] ring_base,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [15:0]       mem_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              done,
  output logic [OUT_W-1:0]  done_bytes,
  output logic              err
);
  typedef enum logic [3:0] {
    S_IDLE, S_CNT, S_SCAN, S_LO0, S_LO1, S_HI, S_OUT, S_FIN, S_ERR
  } st_t;

  st_t               st;
  logic              rv;
  logic [BASE_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q, k_q;
  logic [SUM_W-1:0]  sum_q;
  logic [31:0]       lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [LEN_W-1:0]  len_q;
  logic [6:0]        hw_off;

  wire [ADDR_W-1:0] desc_base = {base_q, {BASE_SHIFT{1'b0}}} + (ADDR_W'(idx_q) << DESC_LOG);
  wire [6:0]        k3        = 7'({k_q, 1'b0}) + 7'(k_q);
  wire [LEN_W-1:0]  len_rd    = mem_rdata[LEN_W+3:4];
  wire [SUM_W-1:0]  sum_nx    = sum_q + SUM_W'(len_rd);
  wire [CNT_W-1:0]  cnt_rd    = mem_rdata[8 +: CNT_W];
  wire              last      = (k_q == cnt_q - 1'b1);
  wire              rd_state  = (st == S_CNT) || (st == S_SCAN) || (st == S_LO0) ||
                                (st == S_LO1) || (st == S_HI);
  wire              got       = rd_state && rv;

  always_comb begin
    case (st)
      S_CNT:        hw_off = 7'd1;
      S_LO0:        hw_off = 7'd2 + k3;
      S_LO1:        hw_off = 7'd3 + k3;
      S_SCAN, S_HI: hw_off = 7'd4 + k3;
      default:      hw_off = 7'd0;
    endcase
  end

  assign mem_rd     = rd_state && !rv;
  assign mem_addr   = desc_base + ADDR_W'({hw_off, 1'b0});
  assign busy       = (st != S_IDLE);
  assign req_valid  = (st == S_OUT);
  assign req_addr   = {hi_q, lo_q};
  assign req_len    = len_q;
  assign done       = (st == S_FIN);
  assign done_bytes = sum_q[OUT_W-1:0];
  assign err        = (st == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rv     <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      k_q    <= '0;
      sum_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      len_q  <= '0;
    end else begin
      if (rd_state) rv <= !rv;
      case (st)
        S_IDLE: if (start) begin
          base_q <= ring_base;
          idx_q  <= start_idx;
          st     <= S_CNT;
        end
        S_CNT: if (got) begin
          cnt_q <= cnt_rd;
          k_q   <= '0;
          sum_q <= '0;
          st    <= (cnt_rd == 0 || cnt_rd > MAX_BUFS) ? S_ERR : S_SCAN;
        end
        S_SCAN: if (got) begin
          sum_q <= sum_nx;
          if (len_rd > BUF_MAX) st <= S_ERR;
          else if (last) begin
            k_q <= '0;
            st  <= (sum_nx > FRAME_MAX) ? S_ERR : S_LO0;
          end else k_q <= k_q + 1'b1;
        end
        S_LO0: if (got) begin
          lo_q[15:0] <= mem_rdata;
          st         <= S_LO1;
        end
        S_LO1: if (got) begin
          lo_q[31:16] <= mem_rdata;
          st          <= S_HI;
        end
        S_HI: if (got) begin
          hi_q  <= mem_rdata[HI_W-1:0];
          len_q <= len_rd;
          st    <= S_OUT;
        end
        S_OUT: if (req_ready) begin
          if (last) st <= S_FIN;
          else begin
            k_q <= k_q + 1'b1;
            st  <= S_LO0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tfd_gather_chk.sv
module tfd_gather_chk #(
  parameter int ADDR_W    = 36,
  parameter int LEN_W     = 12,
  parameter int OUT_W     = 14,
  parameter int FRAME_MAX = 8192
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              mem_rd,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              done,
  input logic [OUT_W-1:0]  done_bytes,
  input logic              err
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !mem_rd && !done && !err);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));
  // R4
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid && req_ready));
  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !req_valid && !done && !mem_rd);
  // R7
  frame_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_bytes <= FRAME_MAX) && (done_bytes != 0));
  // R8
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind tfd_gather tfd_gather_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OUT_W(OUT_W), .FRAME_MAX(FRAME_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_rd(mem_rd),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_len(req_len), .done(done), .done_bytes(done_bytes), .err(err)
);

// File: tb/sim_tfd_gather.sv
module sim_tfd_gather;
  logic        clk = 0, rst_n = 0, start = 0, req_ready = 0;
  logic [7:0]  start_idx = 0;
  logic [27:0] ring_base = 28'hABCDE00;
  logic        busy, mem_rd, req_valid, done, err;
  logic [35:0] mem_addr, req_addr;
  logic [15:0] mem_rdata;
  logic [11:0] req_len;
  logic [13:0] done_bytes;

  localparam logic [35:0] BASE_B = 36'hABCDE0000;

  tfd_gather u0 (.*);

  always #10 clk = ~clk;

  logic [15:0] mem [0:4095];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[12:1]];

  int checks = 0, fails = 0, addr_bad = 0;
  logic [7:0]  cur_idx = 0;
  logic [35:0] exp_addr [0:19];
  int          exp_len  [0:19];

  always @(negedge clk)
    if (rst_n && mem_rd && (((mem_addr & ~36'h1FFF) != BASE_B) || (mem_addr[12:7] != cur_idx[5:0])))
      addr_bad++;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_count(int idx, int raw);
    mem[idx*64+1] = {8'(raw), 8'h5A};
  endtask

  task automatic put_entry(int idx, int k, logic [35:0] a, int len);
    int h = idx*64 + 2 + 3*k;
    mem[h]   = a[15:0];
    mem[h+1] = a[31:16];
    mem[h+2] = {12'(len), a[35:32]};
    exp_addr[k] = a;
    exp_len[k]  = len;
  endtask

  task automatic fill(int idx, int n, int seed);
    put_count(idx, n);
    for (int k = 0; k < n; k++)
      put_entry(idx, k, {4'(k + seed), 32'(seed * 32'h01010101 + k * 32'h00100013)},
                (seed * 7 + k * 53) % 300 + 1);
  endtask

  task automatic run(int idx, int n, bit exp_err, int stall, bit poke, string tag);
    int got = 0, done_cyc = -10, last_acc = -20, bytes = 0, sum = 0, bad0 = addr_bad;
    bit err_seen = 0, done_seen = 0, fin = 0;
    for (int k = 0; k < n; k++) sum += exp_len[k];
    @(negedge clk);
    start = 1; start_idx = 8'(idx); cur_idx = 8'(idx);
    @(negedge clk);
    start = 0;
    for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
      if (poke && cyc == 3) begin start = 1; start_idx = 8'(idx + 1); end
      else start = 0;
      if (done) begin done_seen = 1; bytes = done_bytes; done_cyc = cyc; fin = 1; end
      if (err) begin err_seen = 1; fin = 1; end
      if (req_valid) begin
        req_ready = (stall == 0) || (cyc % stall != 0);
        if (req_ready) begin
          if (got < 20) begin
            chk(req_addr == exp_addr[got], tag, "request address", req_addr, exp_addr[got]);
            chk(req_len == 12'(exp_len[got]), tag, "request length", req_len, exp_len[got]);
          end
          got++;
          last_acc = cyc;
        end
      end else req_ready = 0;
      @(negedge clk);
    end
    req_ready = 0; start = 0;
    chk(got == (exp_err ? 0 : n), tag, "request count", got, exp_err ? 0 : n);
    chk(err_seen == exp_err, tag, "error pulse", err_seen, exp_err);
    if (!exp_err) begin
      chk(done_seen, "R4", "done seen", done_seen, 1);
      chk(done_cyc == last_acc + 1, "R4", "done cycle", done_cyc, last_acc + 1);
      chk(bytes == sum, "R4", "done bytes", bytes, sum);
    end
    repeat (2) @(negedge clk);
    chk(!busy && !err && !req_valid, tag, "idle after finish", busy, 0);
    chk(addr_bad == bad0, "R2", "descriptor read address", addr_bad - bad0, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({busy, req_valid, mem_rd, done, err} == 5'b0, "R1", "reset outputs",
        {busy, req_valid, mem_rd, done, err}, 0);
  endtask

  task automatic t_basic;
    fill(5, 3, 1);
    run(5, 3, 0, 0, 0, "R3");
    fill(9, 4, 2);
    run(9, 4, 0, 3, 0, "R3");
  endtask

  task automatic t_max;
    fill(63, 20, 3);
    run(63, 20, 0, 2, 0, "R9");
  endtask

  task automatic t_count;
    fill(10, 2, 4); put_count(10, 0);
    run(10, 0, 1, 0, 0, "R5");
    fill(11, 20, 5); put_count(11, 21);
    run(11, 0, 1, 0, 0, "R5");
    fill(12, 2, 6); put_count(12, 8'hE2);
    run(12, 2, 0, 0, 0, "R2");
  endtask

  task automatic t_buflen;
    fill(13, 2, 7); put_entry(13, 1, 36'h123456789, 4093);
    run(13, 0, 1, 0, 0, "R6");
    put_count(14, 1); put_entry(14, 0, 36'hF0000FFFE, 4092);
    run(14, 1, 0, 0, 0, "R6");
  endtask

  task automatic t_frame;
    put_count(15, 3);
    put_entry(15, 0, 36'h100000000, 4092);
    put_entry(15, 1, 36'h200001000, 4092);
    put_entry(15, 2, 36'h300002000, 8);
    run(15, 3, 0, 2, 0, "R7");
    put_count(16, 3);
    put_entry(16, 0, 36'h100000000, 4092);
    put_entry(16, 1, 36'h200001000, 4092);
    put_entry(16, 2, 36'h300002000, 9);
    run(16, 0, 1, 0, 0, "R7");
  endtask

  task automatic t_busy;
    put_count(21, 0);
    fill(20, 3, 8);
    run(20, 3, 0, 2, 1, "R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_basic;
    t_max;
    t_count;
    t_buflen;
    t_frame;
    t_busy;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule